// File: doc/BRIEF.md
# General-Purpose Timer Time Base

This block is the counting core of a general-purpose timer. A programmable prescaler divides the timer clock. Its output ticks a 16-bit counter, which runs in one of three ways: upward to a period value, downward from the period value, or back and forth between the two ends. Each time the count wraps, the block raises an update event. That event sets a sticky interrupt flag and loads the buffered configuration into the active registers.

Software sets up the block through a write-only port with five word addresses. It can write a period value and a divide ratio. Both are kept in preload registers. The divide ratio reaches the active prescaler only on an update event. The period can either take effect immediately or wait for the next update event. A control bit can suppress update events completely. While they are suppressed, the count still wraps, but no reload happens and the flag is not set. The count value and the counting direction are visible at the outputs.

Top module: `tmr_base`

## Requirements
- R1: After reset the count is 0, the flag is 0 and the direction is 0 (up). The active period is all ones and the active divide value is 0. All control bits are 0.
- R2: In edge mode with direction 0, a tick at count == period sets the count to 0 and produces an update event. Any other tick adds 1 to the count.
- R3: In edge mode with direction 1, a tick at count 0 reloads the count with the period and produces an update event. Any other tick subtracts 1. The period used for the reload is the preload value when the period is buffered and events are enabled, and the active value otherwise.
- R4: In center mode (CTRL bit 4 = 1), counting up from P-1 loads P, sets the direction to 1 and produces an event. Counting down from 1 loads 0, sets the direction to 0 and produces an event.
- R5: When the period-buffer enable (CTRL bit 2) is 0, a write to PERIOD (address 1) changes the active period on the same clock edge.
- R6: When the period-buffer enable is 1, a write to PERIOD changes only the preload register. The preload is copied to the active period on the next update event.
- R7: When the event-disable bit (CTRL bit 1) is 1, a wrap produces no update event. The active period and the active divide value keep their old values, and the flag is not set.
- R8: A write to DIV (address 2) changes only the preload. On an update event the prescaler takes the preload and restarts at 0. It then ticks once every DIV+1 clocks.
- R9: The direction is written through CTRL bit 3 in edge mode. A write of that bit while center mode is already active is ignored.
- R10: The flag is set by an update event. Writing 0 to bit 0 of FLAG (address 4) clears it, and writing 1 has no effect. A set and a clear on the same edge leave the flag set.
- R11: When the run bit (CTRL bit 0) is 0, both the counter and the prescaler hold their values. Setting it back to 1 continues from the held state.
- R12: A write to COUNT (address 3) loads the count. On the same edge this write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 CTRL, 1 PERIOD, 2 DIV, 3 COUNT, 4 FLAG |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 16 | Current count |
| dir_o | output | 1 | Counting direction, 1 = down |
| flag_o | output | 1 | Update interrupt flag |

## Verification
The hardest case to reach is a single edge where a flag clear meets a hardware set. The table reaches it by placing the counter one tick below the center-mode turning point and then issuing the FLAG write, so that both land on the same edge. Another hard case is a divide ratio written while events are suppressed. The stimulus writes it, checks that ticks still arrive every clock, and only then re-enables events. Counting through an underflow then shows the ratio taking effect with a prescaler restarted at 0. The freeze case stops the run bit partway through a prescaler period. The remaining prescaler phase then becomes visible when counting resumes.

// File: rtl/tmr_base_pkg.sv
package tmr_base_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_UDIS   = 1;
  localparam int unsigned B_BUF    = 2;
  localparam int unsigned B_DIR    = 3;
  localparam int unsigned B_CENTER = 4;

  typedef struct packed {
    logic center;
    logic buf_en;
    logic upd_dis;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_base_regs.sv
module tmr_base_regs
  import tmr_base_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PSC_W   = 16,
  parameter logic [CNT_W-1:0] PER_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              uev_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  per_act_o,
  output logic [CNT_W-1:0]  per_pre_o,
  output logic [PSC_W-1:0]  div_act_o,
  output logic              flag_o,
  output logic              dir_wr_o,
  output logic              dir_wdata_o,
  output logic              cnt_wr_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] per_act_q, per_pre_q;
  logic [PSC_W-1:0] div_act_q, div_pre_q;
  logic             flag_q;
  logic             wr_ctrl, wr_per, wr_div, wr_flag;

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_per  = wr_en_i && (wr_addr_i == A_PER);
  assign wr_div  = wr_en_i && (wr_addr_i == A_DIV);
  assign wr_flag = wr_en_i && (wr_addr_i == A_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      per_act_q <= PER_RST;
      per_pre_q <= PER_RST;
      div_act_q <= '0;
      div_pre_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run     <= wr_data_i[B_RUN];
        ctrl_q.upd_dis <= wr_data_i[B_UDIS];
        ctrl_q.buf_en  <= wr_data_i[B_BUF];
        ctrl_q.center  <= wr_data_i[B_CENTER];
      end
      if (wr_per) begin
        per_pre_q <= wr_data_i[CNT_W-1:0];
        if (!ctrl_q.buf_en) per_act_q <= wr_data_i[CNT_W-1:0];
      end
      if (wr_div) div_pre_q <= wr_data_i[PSC_W-1:0];
      if (uev_i) begin
        div_act_q <= div_pre_q;
        if (ctrl_q.buf_en) per_act_q <= per_pre_q;
      end
      // hardware set outranks software clear
      if (uev_i)                       flag_q <= 1'b1;
      else if (wr_flag && !wr_data_i[0]) flag_q <= 1'b0;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign per_act_o   = per_act_q;
  assign per_pre_o   = per_pre_q;
  assign div_act_o   = div_act_q;
  assign flag_o      = flag_q;
  assign dir_wr_o    = wr_ctrl;
  assign dir_wdata_o = wr_data_i[B_DIR];
  assign cnt_wr_o    = wr_en_i && (wr_addr_i == A_CNT);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uev_i |=> flag_q);
  a_r7_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uev_i |=> $stable(div_act_q));
  a_r6_per_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.buf_en && !uev_i) |=> $stable(per_act_q));
  a_r5_per_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_per && !ctrl_q.buf_en) |=> per_act_q == $past(wr_data_i[CNT_W-1:0]));
endmodule

// File: rtl/tmr_base_psc.sv
module tmr_base_psc #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             uev_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q;

  assign tick_o = run_i && (psc_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (uev_i)  psc_q <= '0;
    else if (run_i)  psc_q <= tick_o ? '0 : psc_q + PSC_W'(1);
  end

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uev_i |=> psc_q == '0);
  a_r11_psc_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !uev_i) |=> $stable(psc_q));
endmodule

// File: rtl/tmr_base_cnt.sv
module tmr_base_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic             upd_dis_i,
  input  logic             buf_en_i,
  input  logic [CNT_W-1:0] per_act_i,
  input  logic [CNT_W-1:0] per_pre_i,
  input  logic             dir_wr_i,
  input  logic             dir_wdata_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, reload;
  logic [CNT_W:0]   cnt_inc;
  logic             dir_q, dir_d, wrap;

  assign cnt_inc = {1'b0, cnt_q} + {1'b0, ONE};
  // reload with the period that becomes active on this event
  assign reload  = (!upd_dis_i && buf_en_i) ? per_pre_i : per_act_i;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (dir_wr_i && !center_i) dir_d = dir_wdata_i;
    if (cnt_wr_i) begin
      cnt_d = cnt_wdata_i;
    end else if (tick_i) begin
      if (!center_i) begin
        if (!dir_q) begin
          if (cnt_q >= per_act_i) begin cnt_d = '0; wrap = 1'b1; end
          else cnt_d = cnt_inc[CNT_W-1:0];
        end else begin
          if (cnt_q == '0) begin cnt_d = reload; wrap = 1'b1; end
          else cnt_d = cnt_q - ONE;
        end
      end else begin
        if (!dir_q) begin
          if (cnt_inc >= {1'b0, per_act_i}) begin
            cnt_d = per_act_i; dir_d = 1'b1; wrap = 1'b1;
          end else cnt_d = cnt_inc[CNT_W-1:0];
        end else begin
          if (cnt_q <= ONE) begin
            cnt_d = '0; dir_d = 1'b0; wrap = 1'b1;
          end else cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign dir_o  = dir_q;
  assign wrap_o = wrap;

  a_r2_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && !center_i && !dir_q && cnt_q == per_act_i) |=> cnt_q == '0);
  a_r4_center_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && center_i && dir_q && cnt_q == ONE) |=> (!dir_q && cnt_q == '0));
  a_r9_dir_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (center_i && !tick_i) |=> $stable(dir_q));
  a_r12_cnt_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_q == $past(cnt_wdata_i));
endmodule

// File: rtl/tmr_base.sv
module tmr_base
  import tmr_base_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PSC_W   = 16,
  parameter logic [CNT_W-1:0] PER_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_o,
  output logic              flag_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] per_act, per_pre;
  logic [PSC_W-1:0] div_act;
  logic             dir_wr, dir_wdata, cnt_wr, tick, wrap, uev;

  assign uev = wrap && !ctrl.upd_dis;

  tmr_base_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .PER_RST(PER_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .uev_i(uev), .ctrl_o(ctrl),
    .per_act_o(per_act), .per_pre_o(per_pre), .div_act_o(div_act),
    .flag_o(flag_o), .dir_wr_o(dir_wr), .dir_wdata_o(dir_wdata), .cnt_wr_o(cnt_wr)
  );

  tmr_base_psc #(.PSC_W(PSC_W)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.run), .uev_i(uev),
    .div_i(div_act), .tick_o(tick)
  );

  tmr_base_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .center_i(ctrl.center), .upd_dis_i(ctrl.upd_dis), .buf_en_i(ctrl.buf_en),
    .per_act_i(per_act), .per_pre_i(per_pre),
    .dir_wr_i(dir_wr), .dir_wdata_i(dir_wdata),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(wr_data_i[CNT_W-1:0]),
    .cnt_o(cnt_o), .dir_o(dir_o), .wrap_o(wrap)
  );

  a_r11_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.run && !cnt_wr) |=> $stable(cnt_o));
  a_r7_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.upd_dis && !flag_o) |=> !flag_o);
endmodule

// File: tb/tmr_base_tb.sv
`timescale 1ns/1ps
module tmr_base_tb;
  typedef struct packed {
    logic [2:0]  addr;   // 7 = no write
    logic [15:0] data;
    logic [7:0]  wait_n;
    logic [15:0] cnt;
    logic        flag;
    logic        dir;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 48;
  // addr, data, wait, cnt, flag, dir, req
  localparam vec_t VECS [NV] = '{
    '{3'd1, 16'h0005, 8'd0,  16'd0, 1'b0, 1'b0, 8'd5},   // R5 immediate period
    '{3'd0, 16'h0001, 8'd5,  16'd5, 1'b0, 1'b0, 8'd2},   // R2 up count
    '{3'd7, 16'h0000, 8'd1,  16'd0, 1'b1, 1'b0, 8'd2},   // R2 wrap
    '{3'd4, 16'h0000, 8'd0,  16'd1, 1'b0, 1'b0, 8'd10},  // R10 clear
    '{3'd0, 16'h0005, 8'd0,  16'd2, 1'b0, 1'b0, 8'd6},
    '{3'd1, 16'h0003, 8'd2,  16'd5, 1'b0, 1'b0, 8'd6},   // R6 held
    '{3'd7, 16'h0000, 8'd1,  16'd0, 1'b1, 1'b0, 8'd6},
    '{3'd7, 16'h0000, 8'd3,  16'd3, 1'b1, 1'b0, 8'd6},
    '{3'd7, 16'h0000, 8'd1,  16'd0, 1'b1, 1'b0, 8'd6},   // R6 new period
    '{3'd0, 16'h000D, 8'd0,  16'd1, 1'b1, 1'b1, 8'd9},   // R9 dir write
    '{3'd4, 16'h0000, 8'd0,  16'd0, 1'b0, 1'b1, 8'd3},
    '{3'd7, 16'h0000, 8'd1,  16'd3, 1'b1, 1'b1, 8'd3},   // R3 underflow
    '{3'd4, 16'h0000, 8'd0,  16'd2, 1'b0, 1'b1, 8'd10},
    '{3'd0, 16'h000F, 8'd0,  16'd1, 1'b0, 1'b1, 8'd7},
    '{3'd1, 16'h0006, 8'd0,  16'd0, 1'b0, 1'b1, 8'd7},
    '{3'd7, 16'h0000, 8'd1,  16'd3, 1'b0, 1'b1, 8'd7},   // R7 no event
    '{3'd7, 16'h0000, 8'd4,  16'd3, 1'b0, 1'b1, 8'd7},
    '{3'd2, 16'h0003, 8'd0,  16'd2, 1'b0, 1'b1, 8'd7},
    '{3'd7, 16'h0000, 8'd2,  16'd0, 1'b0, 1'b1, 8'd7},   // R7 div not loaded
    '{3'd0, 16'h000D, 8'd0,  16'd3, 1'b0, 1'b1, 8'd7},
    '{3'd7, 16'h0000, 8'd3,  16'd0, 1'b0, 1'b1, 8'd3},
    '{3'd7, 16'h0000, 8'd1,  16'd6, 1'b1, 1'b1, 8'd6},   // R6 R3 reload preload
    '{3'd7, 16'h0000, 8'd3,  16'd6, 1'b1, 1'b1, 8'd8},   // R8 divide by 4
    '{3'd7, 16'h0000, 8'd1,  16'd5, 1'b1, 1'b1, 8'd8},
    '{3'd0, 16'h000C, 8'd0,  16'd5, 1'b1, 1'b1, 8'd11},  // R11 stop
    '{3'd7, 16'h0000, 8'd10, 16'd5, 1'b1, 1'b1, 8'd11},
    '{3'd0, 16'h000D, 8'd0,  16'd5, 1'b1, 1'b1, 8'd11},
    '{3'd7, 16'h0000, 8'd2,  16'd5, 1'b1, 1'b1, 8'd11},
    '{3'd7, 16'h0000, 8'd1,  16'd4, 1'b1, 1'b1, 8'd11},  // R11 resumed phase
    '{3'd2, 16'h0000, 8'd0,  16'd4, 1'b1, 1'b1, 8'd8},
    '{3'd7, 16'h0000, 8'd19, 16'd6, 1'b1, 1'b1, 8'd8},
    '{3'd7, 16'h0000, 8'd1,  16'd5, 1'b1, 1'b1, 8'd8},   // R8 div 0 loaded
    '{3'd4, 16'h0000, 8'd0,  16'd4, 1'b0, 1'b1, 8'd10},
    '{3'd0, 16'h0015, 8'd0,  16'd3, 1'b0, 1'b0, 8'd9},
    '{3'd7, 16'h0000, 8'd1,  16'd4, 1'b0, 1'b0, 8'd4},
    '{3'd7, 16'h0000, 8'd1,  16'd5, 1'b0, 1'b0, 8'd4},
    '{3'd7, 16'h0000, 8'd1,  16'd6, 1'b1, 1'b1, 8'd4},   // R4 turn at P-1
    '{3'd4, 16'h0000, 8'd0,  16'd5, 1'b0, 1'b1, 8'd4},
    '{3'd7, 16'h0000, 8'd4,  16'd1, 1'b0, 1'b1, 8'd4},
    '{3'd7, 16'h0000, 8'd1,  16'd0, 1'b1, 1'b0, 8'd4},   // R4 turn at 1
    '{3'd7, 16'h0000, 8'd1,  16'd1, 1'b1, 1'b0, 8'd4},
    '{3'd0, 16'h001D, 8'd0,  16'd2, 1'b1, 1'b0, 8'd9},   // R9 ignored
    '{3'd3, 16'h0001, 8'd0,  16'd1, 1'b1, 1'b0, 8'd12},  // R12 count load
    '{3'd7, 16'h0000, 8'd1,  16'd2, 1'b1, 1'b0, 8'd12},
    '{3'd7, 16'h0000, 8'd3,  16'd5, 1'b1, 1'b0, 8'd4},
    '{3'd4, 16'h0000, 8'd0,  16'd6, 1'b1, 1'b1, 8'd10},  // R10 set wins
    '{3'd0, 16'h0015, 8'd0,  16'd5, 1'b1, 1'b1, 8'd9},   // R9 ignored again
    '{3'd4, 16'h0001, 8'd0,  16'd4, 1'b1, 1'b1, 8'd10}   // R10 write 1 no effect
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt;
  logic        dir, flag;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmr_base u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cnt_o(cnt), .dir_o(dir), .flag_o(flag)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // called at a falling edge; spans exactly one rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cnt", cnt, 16'd0);
    check("R1 reset flag", {15'd0, flag}, 16'd0);
    check("R1 reset dir", {15'd0, dir}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].addr != 3'd7) wr(VECS[i].addr, VECS[i].data);
      for (int k = 0; k < int'(VECS[i].wait_n); k++) @(negedge clk);
      check($sformatf("R%0d vec %0d cnt", VECS[i].req, i), cnt, VECS[i].cnt);
      check($sformatf("R%0d vec %0d flag", VECS[i].req, i), {15'd0, flag}, {15'd0, VECS[i].flag});
      check($sformatf("R%0d vec %0d dir", VECS[i].req, i), {15'd0, dir}, {15'd0, VECS[i].dir});
    end
    // R1: asynchronous reset mid-run, then reset period all ones and div 0
    #3 rst_n = 1'b0;
    #2;
    check("R1 async reset cnt", cnt, 16'd0);
    check("R1 async reset flag", {15'd0, flag}, 16'd0);
    check("R1 async reset dir", {15'd0, dir}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr(3'd3, 16'hFFFE);
    wr(3'd0, 16'h0001);
    @(negedge clk);
    check("R1 R2 reset period reaches all ones", cnt, 16'hFFFF);
    check("R1 R2 no wrap below period", {15'd0, flag}, 16'd0);
    @(negedge clk);
    check("R2 wrap at reset period", cnt, 16'd0);
    check("R2 flag on wrap", {15'd0, flag}, 16'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule